// File: doc/BRIEF.md
# Configurable Async Serial Channel

This block is one full-duplex asynchronous serial channel. Three configuration bytes set its character format. A receive byte gives the receive character length and the receiver enable. A shared mode byte gives the stop-bit count and the parity settings. A transmit byte gives the transmit character length, the transmitter enable and the RTS level. Receive and transmit lengths are set separately, so the two directions may use different lengths.

A one-clock pulse on `tick16_i` marks each period of a bit clock running at 16 times the data rate. A single-byte holding buffer feeds the transmitter. A single-byte buffer catches each received character. Software-visible state is reduced to a status byte with two flags at fixed positions, plus overrun, parity-error and framing-error flags. Bus decode and baud-clock generation belong to the surrounding logic.

Top module: `async_serial_chan`

## Requirements
- R1: After reset, `txd_o` is high, `status_o` reads 8'h04 (transmit buffer empty, nothing received) and `overrun_o` is low.
- R2: A transmitted frame is a low start bit of 16 ticks, then the data bits LSB first, each lasting 16 ticks. The data-bit count comes from transmit byte bits 6:5 (00=8, 01=7, 10=6, 11=5).
- R3: When mode bit 0 is set, one parity bit follows the data bits. Mode bit 1 set selects even parity, meaning the data ones plus the parity bit total an even number. Mode bit 1 clear selects odd parity. Mode bit 1 has no effect while bit 0 is clear.
- R4: Mode bits 3:2 set the high time after the last data or parity bit before the next start bit: 01 gives 16 ticks, 10 gives 24 ticks and 11 gives 32 ticks. With 00, neither direction accepts a new character.
- R5: Status bit 2 is set while the transmit buffer is empty. A write while it is set fills the buffer and clears the bit. A write while it is clear is ignored. The bit sets again when the transmitter takes the character.
- R6: Receive byte bits 7:6 give the receive length with the same encoding as R2. Receive byte bit 0 enables the receiver. Transmit byte bit 3 enables the transmitter. A disabled transmitter keeps the line high and holds its buffer.
- R7: The receiver re-checks a start bit 8 ticks after detecting it. A start bit that is high again by then is dropped and no character is delivered. Each data bit is then sampled every 16 ticks.
- R8: Status bit 0 sets when a character is delivered to `rx_data_o`, and a read pulse clears it. A character delivered while bit 0 is still set replaces the buffer and raises `overrun_o`. A read clears `overrun_o`.
- R9: `parity_err_o` reports a parity mismatch for the buffered character. `frame_err_o` reports a low first stop bit. Both are updated with each delivered character.
- R10: `rts_o` follows transmit byte bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick16_i | input | 1 | One-cycle enable at 16x the bit rate |
| rx_cfg_i | input | 8 | Receive length (7:6), receiver enable (0) |
| mode_cfg_i | input | 8 | Stop bits (3:2), parity sense (1), parity enable (0) |
| tx_cfg_i | input | 8 | Transmit length (6:5), transmitter enable (3), RTS (1) |
| tx_wr_i | input | 1 | Write pulse for the transmit buffer |
| tx_data_i | input | 8 | Transmit character |
| rx_rd_i | input | 1 | Read pulse for the receive buffer |
| rx_data_o | output | 8 | Received character, right aligned |
| status_o | output | 8 | Bit 2 transmit empty, bit 0 character available |
| overrun_o | output | 1 | Character lost to an unread buffer |
| parity_err_o | output | 1 | Parity mismatch on the buffered character |
| frame_err_o | output | 1 | Low stop bit on the buffered character |
| rts_o | output | 1 | Line-driver enable |
| rxd_i | input | 1 | Serial input |
| txd_o | output | 1 | Serial output |

## Verification
The assertions check the buffer handshakes on every cycle. A write to an empty transmit buffer always claims it. A full buffer never drains while the transmitter is off or the stop code is 00. A read always clears the overrun flag, and overrun never stands without a waiting character. Line timing cannot be seen from one cycle to the next, so the bench's scenarios have to show it: the start-to-start period for every length, parity and stop combination, bit order, parity bit value, glitch rejection, error flags and the dropped write.

// File: rtl/asc_pkg.sv
package asc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } phase_e;

  typedef struct packed {
    logic [3:0] len;
    logic       par_en;
    logic       par_even;
    logic [1:0] stop_code;
  } fmt_t;

  // 00=8, 01=7, 10=6, 11=5
  function automatic logic [3:0] len_of(input logic [1:0] code);
    return 4'd8 - {2'b00, code};
  endfunction

endpackage

// File: rtl/asc_cfg_decode.sv
module asc_cfg_decode
  import asc_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic [CFG_W-1:0] rx_cfg_i,
  input  logic [CFG_W-1:0] mode_cfg_i,
  input  logic [CFG_W-1:0] tx_cfg_i,
  output fmt_t             rx_fmt_o,
  output fmt_t             tx_fmt_o,
  output logic             rx_en_o,
  output logic             tx_en_o,
  output logic             rts_o
);
  logic async_ok;

  assign async_ok = (mode_cfg_i[3:2] != 2'b00);

  always_comb begin
    rx_fmt_o.len       = len_of(rx_cfg_i[7:6]);
    rx_fmt_o.par_en    = mode_cfg_i[0];
    rx_fmt_o.par_even  = mode_cfg_i[1];
    rx_fmt_o.stop_code = mode_cfg_i[3:2];
    tx_fmt_o.len       = len_of(tx_cfg_i[6:5]);
    tx_fmt_o.par_en    = mode_cfg_i[0];
    tx_fmt_o.par_even  = mode_cfg_i[1];
    tx_fmt_o.stop_code = mode_cfg_i[3:2];
  end

  assign rx_en_o = rx_cfg_i[0] & async_ok;
  assign tx_en_o = tx_cfg_i[3] & async_ok;
  assign rts_o   = tx_cfg_i[1];

endmodule

// File: rtl/asc_sync.sv
module asc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= 1'b1;
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/asc_tx.sv
module asc_tx
  import asc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OS     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  fmt_t              fmt_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              empty_o,
  output logic              txd_o
);
  localparam int CW = $clog2(2*OS) + 1;
  localparam int BW = $clog2(DATA_W) + 1;

  phase_e            ph_q;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] buf_q, sh_q;
  logic              full_q, par_q;
  fmt_t              fmt_q;

  logic [CW-1:0]     stop_last;
  logic              bit_end, load;
  logic [DATA_W-1:0] masked;
  logic              par_in;

  always_comb begin
    case (fmt_q.stop_code)
      2'b10:   stop_last = CW'(OS + OS/2 - 1);
      2'b11:   stop_last = CW'(2*OS - 1);
      default: stop_last = CW'(OS - 1);
    endcase
  end

  assign bit_end = (cnt_q == CW'(OS - 1));
  assign masked  = buf_q & ({DATA_W{1'b1}} >> (DATA_W - int'(fmt_i.len)));
  assign par_in  = fmt_i.par_even ? ^masked : ~^masked;
  // next frame may start on the very tick the previous stop time ends
  assign load    = tick_i && full_q && en_i &&
                   (ph_q == PH_IDLE || (ph_q == PH_STOP && cnt_q == stop_last));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      buf_q  <= '0;
      sh_q   <= '0;
      full_q <= 1'b0;
      par_q  <= 1'b0;
      fmt_q  <= '0;
    end else begin
      if (wr_i && !full_q) begin
        buf_q  <= data_i;
        full_q <= 1'b1;
      end
      if (load) begin
        full_q <= 1'b0;
        sh_q   <= buf_q;
        fmt_q  <= fmt_i;
        par_q  <= par_in;
        ph_q   <= PH_START;
        cnt_q  <= '0;
      end else if (tick_i) begin
        case (ph_q)
          PH_START: begin
            if (bit_end) begin
              ph_q  <= PH_DATA;
              cnt_q <= '0;
              bit_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
          PH_DATA: begin
            if (bit_end) begin
              cnt_q <= '0;
              sh_q  <= sh_q >> 1;
              if (bit_q == BW'(fmt_q.len) - 1'b1)
                ph_q <= fmt_q.par_en ? PH_PAR : PH_STOP;
              else bit_q <= bit_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          PH_PAR: begin
            if (bit_end) begin
              ph_q  <= PH_STOP;
              cnt_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
          PH_STOP: begin
            if (cnt_q == stop_last) begin
              ph_q  <= PH_IDLE;
              cnt_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: ph_q <= PH_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (ph_q)
      PH_START: txd_o = 1'b0;
      PH_DATA:  txd_o = sh_q[0];
      PH_PAR:   txd_o = par_q;
      default:  txd_o = 1'b1;
    endcase
  end

  assign empty_o = !full_q;

endmodule

// File: rtl/asc_rx.sv
module asc_rx
  import asc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OS     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  fmt_t              fmt_i,
  input  logic              rxd_i,
  output logic              dlv_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o
);
  localparam int CW = $clog2(OS) + 1;
  localparam int BW = $clog2(DATA_W) + 1;

  phase_e            ph_q;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_q;
  fmt_t              fmt_q;

  logic              bit_end, mid_start;
  logic [DATA_W-1:0] aligned;
  logic              par_exp;

  assign bit_end   = (cnt_q == CW'(OS - 1));
  assign mid_start = (cnt_q == CW'(OS/2 - 1));
  assign aligned   = sh_q >> (DATA_W - int'(fmt_q.len));
  assign par_exp   = fmt_q.par_even ? ^aligned : ~^aligned;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      fmt_q  <= '0;
      dlv_o  <= 1'b0;
      data_o <= '0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
    end else begin
      dlv_o <= 1'b0;
      if (!en_i) begin
        ph_q  <= PH_IDLE;
        cnt_q <= '0;
      end else if (tick_i) begin
        case (ph_q)
          PH_IDLE: begin
            if (!rxd_i) begin
              ph_q  <= PH_START;
              cnt_q <= '0;
              fmt_q <= fmt_i;
            end
          end
          PH_START: begin
            if (mid_start) begin
              ph_q  <= rxd_i ? PH_IDLE : PH_DATA;
              cnt_q <= '0;
              bit_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
          PH_DATA: begin
            if (bit_end) begin
              cnt_q <= '0;
              sh_q  <= {rxd_i, sh_q[DATA_W-1:1]};
              if (bit_q == BW'(fmt_q.len) - 1'b1)
                ph_q <= fmt_q.par_en ? PH_PAR : PH_STOP;
              else bit_q <= bit_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          PH_PAR: begin
            if (bit_end) begin
              par_q <= rxd_i;
              ph_q  <= PH_STOP;
              cnt_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
          PH_STOP: begin
            if (bit_end) begin
              dlv_o  <= 1'b1;
              data_o <= aligned;
              perr_o <= fmt_q.par_en && (par_q != par_exp);
              ferr_o <= !rxd_i;
              ph_q   <= PH_IDLE;
              cnt_q  <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: ph_q <= PH_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/async_serial_chan.sv
module async_serial_chan
  import asc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OS          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick16_i,
  input  logic [7:0]        rx_cfg_i,
  input  logic [7:0]        mode_cfg_i,
  input  logic [7:0]        tx_cfg_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [7:0]        status_o,
  output logic              overrun_o,
  output logic              parity_err_o,
  output logic              frame_err_o,
  output logic              rts_o,
  input  logic              rxd_i,
  output logic              txd_o
);
  localparam int ST_AVAIL = 0;
  localparam int ST_EMPTY = 2;

  fmt_t              rx_fmt, tx_fmt;
  logic              rx_en, tx_en, tx_empty, rxd_s;
  logic              dlv, d_perr, d_ferr;
  logic [DATA_W-1:0] d_data;

  logic [DATA_W-1:0] rx_buf_q;
  logic              avail_q, ovr_q, perr_q, ferr_q;

  asc_cfg_decode #(.CFG_W(8)) i_cfg (
    .rx_cfg_i   (rx_cfg_i),
    .mode_cfg_i (mode_cfg_i),
    .tx_cfg_i   (tx_cfg_i),
    .rx_fmt_o   (rx_fmt),
    .tx_fmt_o   (tx_fmt),
    .rx_en_o    (rx_en),
    .tx_en_o    (tx_en),
    .rts_o      (rts_o)
  );

  asc_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rxd_i),
    .q_o    (rxd_s)
  );

  asc_tx #(.DATA_W(DATA_W), .OS(OS)) i_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick16_i),
    .en_i    (tx_en),
    .fmt_i   (tx_fmt),
    .wr_i    (tx_wr_i),
    .data_i  (tx_data_i),
    .empty_o (tx_empty),
    .txd_o   (txd_o)
  );

  asc_rx #(.DATA_W(DATA_W), .OS(OS)) i_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick16_i),
    .en_i   (rx_en),
    .fmt_i  (rx_fmt),
    .rxd_i  (rxd_s),
    .dlv_o  (dlv),
    .data_o (d_data),
    .perr_o (d_perr),
    .ferr_o (d_ferr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_buf_q <= '0;
      avail_q  <= 1'b0;
      ovr_q    <= 1'b0;
      perr_q   <= 1'b0;
      ferr_q   <= 1'b0;
    end else begin
      if (rx_rd_i) begin
        avail_q <= 1'b0;
        ovr_q   <= 1'b0;
      end
      if (dlv) begin
        rx_buf_q <= d_data;
        avail_q  <= 1'b1;
        perr_q   <= d_perr;
        ferr_q   <= d_ferr;
        if (avail_q && !rx_rd_i) ovr_q <= 1'b1;
      end
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[ST_EMPTY] = tx_empty;
    status_o[ST_AVAIL] = avail_q;
  end

  assign rx_data_o    = rx_buf_q;
  assign overrun_o    = ovr_q;
  assign parity_err_o = perr_q;
  assign frame_err_o  = ferr_q;

endmodule

// File: rtl/asc_chk.sv
module asc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_wr_i,
  input logic       rx_rd_i,
  input logic [7:0] tx_cfg_i,
  input logic [7:0] mode_cfg_i,
  input logic [7:0] status_o,
  input logic       overrun_o
);

  assert_wr_claims_buf_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_i && status_o[2] |=> !status_o[2]);

  // R4 (stop code 00) and R6 (transmitter off): a full buffer stays full
  assert_hold_when_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_cfg_i[3] || mode_cfg_i[3:2] == 2'b00) && !status_o[2] |=> !status_o[2]);

  assert_read_clears_ovr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rd_i |=> !overrun_o);

  assert_ovr_needs_avail_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> status_o[0]);

endmodule

bind async_serial_chan asc_chk i_asc_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_wr_i    (tx_wr_i),
  .rx_rd_i    (rx_rd_i),
  .tx_cfg_i   (tx_cfg_i),
  .mode_cfg_i (mode_cfg_i),
  .status_o   (status_o),
  .overrun_o  (overrun_o)
);

// File: tb/test_async_serial_chan.sv
module test_async_serial_chan;
  localparam int P   = 4;
  localparam int OS  = 16;
  localparam int BIT = OS * P;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_ni = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] rx_cfg, mode_cfg, tx_cfg;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_data = '0;
  logic       rx_rd = 1'b0;
  logic       bench_rxd = 1'b1;
  logic       loop_sel = 1'b0;
  logic       rxd;
  logic [7:0] rx_data, status;
  logic       overrun, perr, ferr, rts, txd;

  int cyc = 0;
  int tc = 0;
  int ntot = 0;
  int nbad = 0;

  assign rxd = loop_sel ? txd : bench_rxd;

  async_serial_chan i_async_serial_chan (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .tick16_i     (tick),
    .rx_cfg_i     (rx_cfg),
    .mode_cfg_i   (mode_cfg),
    .tx_cfg_i     (tx_cfg),
    .tx_wr_i      (tx_wr),
    .tx_data_i    (tx_data),
    .rx_rd_i      (rx_rd),
    .rx_data_o    (rx_data),
    .status_o     (status),
    .overrun_o    (overrun),
    .parity_err_o (perr),
    .frame_err_o  (ferr),
    .rts_o        (rts),
    .rxd_i        (rxd),
    .txd_o        (txd)
  );

  always @(negedge clk) begin
    cyc  <= cyc + 1;
    tc   <= (tc == P-1) ? 0 : tc + 1;
    tick <= (tc == P-1);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    ntot++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_fmt(input int lc, input bit pe, input bit ev, input int sc);
    rx_cfg   = {lc[1:0], 5'b0, 1'b1};
    tx_cfg   = {1'b0, lc[1:0], 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    mode_cfg = {4'b0, sc[1:0], ev, pe};
  endtask

  task automatic wr_tx(input logic [7:0] d);
    tx_data = d;
    tx_wr   = 1'b1;
    step(1);
    tx_wr   = 1'b0;
  endtask

  task automatic rd_rx();
    rx_rd = 1'b1;
    step(1);
    rx_rd = 1'b0;
    step(1);
  endtask

  task automatic wait_txd_low(output int t);
    int n = 0;
    while (txd !== 1'b0 && n < 4000) begin step(1); n++; end
    t = cyc;
    check(n < 4000, "R2", "start bit seen", n, 0);
  endtask

  task automatic wait_avail();
    int n = 0;
    while (status[0] !== 1'b1 && n < 4000) begin step(1); n++; end
    check(n < 4000, "R8", "character delivered", n, 0);
  endtask

  function automatic logic [7:0] lmask(input int len);
    return 8'hFF >> (8 - len);
  endfunction

  task automatic drive_frame(input logic [7:0] d, input int len, input bit pe,
                             input bit ev, input bit bad_par, input int stop_low);
    logic [7:0] md;
    md = d & lmask(len);
    bench_rxd = 1'b0; step(BIT);
    for (int i = 0; i < len; i++) begin bench_rxd = md[i]; step(BIT); end
    if (pe) begin
      bench_rxd = (ev ? ^md : ~^md) ^ bad_par;
      step(BIT);
    end
    if (stop_low > 0) begin bench_rxd = 1'b0; step(stop_low); end
    bench_rxd = 1'b1;
    step(2*BIT);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual=%0d expected=done", cyc);
    ntot++; nbad++;
    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

  initial begin
    int t1, t2, len, stp, pe, ev;
    logic [7:0] c1, c2, md;
    set_fmt(0, 0, 0, 1);
    step(5);
    // R1 reset state
    check(status == 8'h04, "R1", "status at reset", status, 8'h04);
    check(txd == 1'b1, "R1", "txd at reset", txd, 1);
    check(overrun == 1'b0, "R1", "overrun at reset", overrun, 0);
    rst_ni = 1'b1;
    step(4);

    // R10 rts follows transmit bit 1
    tx_cfg[1] = 1'b0; step(1);
    check(rts == 1'b0, "R10", "rts low", rts, 0);
    tx_cfg[1] = 1'b1; step(1);
    check(rts == 1'b1, "R10", "rts high", rts, 1);

    // R2 R3 R4 loopback sweep: lengths x parity modes x stop codes
    loop_sel = 1'b1;
    for (int lc = 0; lc < 4; lc++)
      for (int pm = 0; pm < 3; pm++)
        for (int sc = 1; sc < 4; sc++) begin
          pe = (pm != 0); ev = (pm == 2);
          len = 8 - lc;
          stp = (sc == 1) ? 16 : (sc == 2) ? 24 : 32;
          set_fmt(lc, pe[0], ev[0], sc);
          step(BIT);
          c1 = 8'hA5 ^ 8'(lc*37 + pm*11 + sc*5);
          c2 = ~c1 ^ 8'(sc);
          wr_tx(c1);
          wait_txd_low(t1);
          wr_tx(c2);
          wait_avail();
          check(rx_data == (c1 & lmask(len)), "R2", "loopback first char",
                rx_data, c1 & lmask(len));
          check(perr == 1'b0, "R3", "no parity error", perr, 0);
          rd_rx();
          wait_txd_low(t2);
          check((t2 - t1) == (1 + len + pe) * BIT + stp * P, "R4",
                "start-to-start period", t2 - t1, (1 + len + pe) * BIT + stp * P);
          wait_avail();
          check(rx_data == (c2 & lmask(len)), "R2", "loopback second char",
                rx_data, c2 & lmask(len));
          rd_rx();
          step(2*BIT);
        end

    // R2 R3 bit order and parity bit value on the line
    for (int k = 0; k < 2; k++) begin
      int lc;
      lc = (k == 0) ? 0 : 3;
      len = 8 - lc;
      ev = (k == 0);
      c1 = (k == 0) ? 8'hB4 : 8'h13;
      md = c1 & lmask(len);
      set_fmt(lc, 1'b1, ev[0], 1);
      step(BIT);
      wr_tx(c1);
      wait_txd_low(t1);
      step(BIT/2);
      check(txd == 1'b0, "R2", "start mid", txd, 0);
      step(BIT);
      for (int i = 0; i < len; i++) begin
        check(txd == md[i], "R2", "data bit LSB first", txd, md[i]);
        step(BIT);
      end
      check(txd == (ev ? ^md : ~^md), "R3", "parity bit", txd, ev ? ^md : ~^md);
      step(BIT);
      check(txd == 1'b1, "R4", "stop level", txd, 1);
      wait_avail();
      rd_rx();
      step(BIT);
    end

    // R6 R9 receive sweep, bench-driven line
    loop_sel = 1'b0;
    for (int lc = 0; lc < 4; lc++)
      for (int pm = 0; pm < 3; pm++)
        for (int v = 0; v < 2; v++) begin
          pe = (pm != 0); ev = (pm == 2); len = 8 - lc;
          c1 = (v == 0) ? 8'h6D ^ 8'(lc) : 8'hC2 ^ 8'(pm);
          set_fmt(lc, pe[0], ev[0], 1);
          step(4);
          drive_frame(c1, len, pe[0], ev[0], 1'b0, 0);
          check(status[0] == 1'b1, "R8", "avail after frame", status[0], 1);
          check(rx_data == (c1 & lmask(len)), "R6", "rx length decode",
                rx_data, c1 & lmask(len));
          check(perr == 1'b0 && ferr == 1'b0, "R9", "clean flags", {perr, ferr}, 0);
          rd_rx();
          check(status[0] == 1'b0, "R8", "read clears avail", status[0], 0);
        end

    // R9 parity error, framing error, flags follow each character
    set_fmt(0, 1'b1, 1'b1, 1);
    step(4);
    drive_frame(8'h5A, 8, 1'b1, 1'b1, 1'b1, 0);
    check(perr == 1'b1, "R9", "parity error flagged", perr, 1);
    check(rx_data == 8'h5A, "R9", "data with parity error", rx_data, 8'h5A);
    rd_rx();
    drive_frame(8'h33, 8, 1'b1, 1'b1, 1'b0, 12*P);
    check(ferr == 1'b1, "R9", "framing error flagged", ferr, 1);
    check(perr == 1'b0, "R9", "parity flag refreshed", perr, 0);
    rd_rx();
    step(2*BIT);
    drive_frame(8'h71, 8, 1'b1, 1'b1, 1'b0, 0);
    check(ferr == 1'b0, "R9", "framing flag refreshed", ferr, 0);
    rd_rx();

    // R3 parity sense ignored when parity off: odd vs even gives same frame
    set_fmt(0, 1'b0, 1'b1, 1);
    step(4);
    drive_frame(8'h0F, 8, 1'b0, 1'b0, 1'b0, 0);
    check(rx_data == 8'h0F && perr == 1'b0, "R3", "sense bit ignored", rx_data, 8'h0F);
    rd_rx();

    // R7 glitch rejection
    set_fmt(0, 1'b0, 1'b0, 1);
    step(4);
    bench_rxd = 1'b0; step(5*P); bench_rxd = 1'b1;
    step(3*BIT);
    check(status[0] == 1'b0, "R7", "glitch dropped", status[0], 0);
    drive_frame(8'h96, 8, 1'b0, 1'b0, 1'b0, 0);
    check(rx_data == 8'h96 && status[0], "R7", "frame after glitch", rx_data, 8'h96);
    rd_rx();

    // R8 overrun
    drive_frame(8'h11, 8, 1'b0, 1'b0, 1'b0, 0);
    drive_frame(8'h22, 8, 1'b0, 1'b0, 1'b0, 0);
    check(overrun == 1'b1, "R8", "overrun set", overrun, 1);
    check(rx_data == 8'h22, "R8", "newer char kept", rx_data, 8'h22);
    rd_rx();
    check(overrun == 1'b0 && status[0] == 1'b0, "R8", "read clears", {overrun, status[0]}, 0);

    // R6 receiver disabled
    rx_cfg[0] = 1'b0;
    step(4);
    drive_frame(8'h44, 8, 1'b0, 1'b0, 1'b0, 0);
    check(status[0] == 1'b0, "R6", "rx disabled ignores line", status[0], 0);
    rx_cfg[0] = 1'b1;

    // R6 R5 transmitter disabled, second write dropped
    loop_sel = 1'b1;
    tx_cfg[3] = 1'b0;
    step(4);
    wr_tx(8'h3C);
    check(status[2] == 1'b0, "R5", "write fills buffer", status[2], 0);
    wr_tx(8'hC3);
    for (int i = 0; i < 6; i++) begin
      step(BIT/2);
      check(txd == 1'b1, "R6", "line idle while tx off", txd, 1);
    end
    check(status[2] == 1'b0, "R6", "buffer held while off", status[2], 0);
    tx_cfg[3] = 1'b1;
    wait_avail();
    check(rx_data == 8'h3C, "R5", "first write sent", rx_data, 8'h3C);
    rd_rx();
    step(4*BIT*10);
    check(status[0] == 1'b0, "R5", "write while full ignored", status[0], 0);
    check(status[2] == 1'b1, "R5", "buffer empty again", status[2], 1);

    // R4 stop code 00 disables both directions
    mode_cfg[3:2] = 2'b00;
    step(4);
    wr_tx(8'h5E);
    step(3*BIT);
    check(status[2] == 1'b0 && txd == 1'b1, "R4", "no send with stop code 00",
          {status[2], txd}, 1);
    mode_cfg[3:2] = 2'b01;
    wait_avail();
    check(rx_data == 8'h5E, "R4", "send after stop code restored", rx_data, 8'h5E);
    rd_rx();

    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

endmodule